// File: doc/BRIEF.md
# Double-Buffered Multichannel PWM Driver

This block produces eighteen independent pulse-width-modulated outputs for LED channels. Every channel has an 8-bit duty value and an enable bit, so its average on-time can be chosen in 256 steps. All channels share one free-running 8-bit phase counter. Each channel has its own comparator and output flop.

Software programs the block through a plain write port: an 8-bit address, 8-bit data and a one-cycle write strobe. Duty and enable writes go into a staging set of registers. They reach the active set that drives the pins only after an update command. The active set is loaded at the next wrap of the phase counter, so no pulse is ever cut short or stretched. A clear command returns every register to its default. A software run bit and an active-low shutdown pin both force the outputs low at once, and the stored settings are kept.

The command sequencer has two states:
- `CMD_IDLE`: the active set is steady.
  - Transition `IDLE->ARMED`: taken on an update command.
  - Transition `IDLE->IDLE`: taken otherwise.
- `CMD_ARMED`: an update is pending.
  - Transition `ARMED->IDLE (load)`: taken at the counter wrap. The staging set is copied into the active set.
  - Transition `ARMED->IDLE (clear)`: taken on a clear command.
  - Transition `ARMED->ARMED`: taken otherwise.

Top module: `ledpwm_bank`

## Requirements
- R1: After reset, every output is low, the run bit is 0 (stopped), and all duty and enable values, staged and active, are zero.
- R2: With the block running and a channel enabled, the channel is high for exactly D cycles out of every 256, where D is its active duty value. D=00h gives an output that is always low, and D=FFh gives 255 high cycles.
- R3: Address 01h+k holds the duty value of channel k+1, for k = 0 to 17. Channel 1 drives `pwm_o[0]`.
- R4: Bit b (b = 0 to 5) at address 13h, 14h or 15h enables channel b+1, b+7 or b+13 respectively. A 0 forces that channel low. Bits 7:6 at these addresses have no effect.
- R5: Writes to addresses 01h–15h change only the staging set. The outputs do not change until 00h is written to address 16h (the update command).
- R6: After an update command, the active set is loaded at the next counter wrap, which is the step from 255 to 0. Every high pulse therefore has the full length of either the old duty or the new duty.
- R7: Writing 00h to address 17h (the clear command) resets all staged values, all active values and the run bit to their defaults. A pending update is cancelled.
- R8: Bit 0 at address 00h is the run bit, where 1 means run and 0 means stop. It takes effect without an update. Within one cycle of a stop, all outputs go low. After a restart, the earlier duty and enable settings appear again.
- R9: While `shdn_n_i` is low, all outputs are low from the next cycle on. Releasing it restores the stored settings.
- R10: The following writes change nothing: a non-zero value to address 16h, a non-zero value to address 17h, and any write to an address above 17h.
- R11: The phase counter advances by one each cycle and wraps from 255 to 0, so every channel's period is 256 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 8 | Register address |
| wr_data_i | input | 8 | Write data |
| shdn_n_i | input | 1 | Active-low shutdown, synchronous to `clk` |
| pwm_o | output | 18 | PWM outputs, bit 0 is channel 1 |

## Verification
The duty function is measured by counting high cycles over a 256-cycle window for several input patterns:
- A full set of eighteen different duties, including 00h and FFh. Any crossed address decode or an off-by-one at the comparator shows up as a wrong count on a specific channel.
- Selectively cleared enable bits, checked before and after an update. These separate a staging leak from a wrong enable-bit position.

An update is issued in the middle of a period while the bench records every high pulse length and the spacing of rising edges. A load that does not wait for the wrap would produce a pulse that is neither the old nor the new length.

The bench also issues commands with non-zero data and writes to unmapped addresses. Each is followed by a check that the outputs are unchanged, and then by an update that shows the staged value survived.

// File: rtl/ledpwm_pkg.sv
`timescale 1ns/1ps
package ledpwm_pkg;

    // Command sequencer states for staging-to-active transfer.
    typedef enum logic [0:0] {
        CMD_IDLE  = 1'b0,
        CMD_ARMED = 1'b1
    } cmd_state_e;

endpackage

// File: rtl/ledpwm_counter.sv
`timescale 1ns/1ps
module ledpwm_counter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] cnt_o,
    output logic          wrap_o
);

    logic [DW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + DW'(1);
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (cnt_q == '1);

    // R11: the top value is followed by zero
    a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '0));

    // R11: single steps below the top value
    a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '1) |=> (cnt_q == $past(cnt_q) + DW'(1)));

endmodule

// File: rtl/ledpwm_regs.sv
`timescale 1ns/1ps
module ledpwm_regs
    import ledpwm_pkg::*;
#(
    parameter int NCH = 18,
    parameter int DW  = 8,
    parameter int AW  = 8,
    parameter int ENB = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [AW-1:0]           wr_addr_i,
    input  logic [DW-1:0]           wr_data_i,
    input  logic                    wrap_i,
    output logic [NCH-1:0][DW-1:0]  duty_act_o,
    output logic [NCH-1:0]          en_act_o,
    output logic                    run_o
);

    // Address map derived from the channel count
    localparam int RUN_A   = 0;
    localparam int DUTY_LO = 1;
    localparam int NEN     = (NCH + ENB - 1) / ENB;
    localparam int EN_LO   = DUTY_LO + NCH;
    localparam int UPD_A   = EN_LO + NEN;
    localparam int CLR_A   = UPD_A + 1;

    cmd_state_e state_q, state_d;

    logic                   run_cmd, upd_cmd, clr_cmd, load;
    logic [NCH-1:0][DW-1:0] duty_stg, duty_act_q;
    logic [NCH-1:0]         en_stg, en_act_q;
    logic                   run_q;

    // Command decode
    always_comb begin
        run_cmd = wr_en_i && (wr_addr_i == AW'(RUN_A));
        upd_cmd = wr_en_i && (wr_addr_i == AW'(UPD_A)) && (wr_data_i == '0);
        clr_cmd = wr_en_i && (wr_addr_i == AW'(CLR_A)) && (wr_data_i == '0);
    end

    // Sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: begin
                if (!clr_cmd && upd_cmd) state_d = CMD_ARMED;
            end
            CMD_ARMED: begin
                if (clr_cmd || wrap_i) state_d = CMD_IDLE;
            end
            default: state_d = CMD_IDLE;
        endcase
    end

    // Sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMD_IDLE;
        else        state_q <= state_d;
    end

    // Sequencer: outputs
    always_comb begin
        load = 1'b0;
        unique case (state_q)
            CMD_IDLE:  load = 1'b0;
            CMD_ARMED: load = wrap_i && !clr_cmd;
            default:   load = 1'b0;
        endcase
    end

    // Staging registers, one slice per channel
    for (genvar c = 0; c < NCH; c++) begin : g_stage
        localparam logic [AW-1:0] DA = AW'(DUTY_LO + c);
        localparam logic [AW-1:0] EA = AW'(EN_LO + c / ENB);
        localparam int            EB = c % ENB;

        logic [DW-1:0] d_q;
        logic          e_q;

        always_ff @(posedge clk) begin
            if (!rst_n || clr_cmd) begin
                d_q <= '0;
                e_q <= 1'b0;
            end else if (wr_en_i) begin
                if (wr_addr_i == DA) d_q <= wr_data_i;
                if (wr_addr_i == EA) e_q <= wr_data_i[EB];
            end
        end

        assign duty_stg[c] = d_q;
        assign en_stg[c]   = e_q;
    end

    // Active set: loaded only by the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cmd) begin
            duty_act_q <= '0;
            en_act_q   <= '0;
        end else if (load) begin
            duty_act_q <= duty_stg;
            en_act_q   <= en_stg;
        end
    end

    // Run bit, not staged
    always_ff @(posedge clk) begin
        if (!rst_n || clr_cmd) run_q <= 1'b0;
        else if (run_cmd)      run_q <= wr_data_i[0];
    end

    assign duty_act_o = duty_act_q;
    assign en_act_o   = en_act_q;
    assign run_o      = run_q;

    // R5: the active set holds unless loaded or cleared
    a_r5_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr_cmd) |=> ($stable(duty_act_q) && $stable(en_act_q)));

    // R6: a load happens only on the cycle of a counter wrap
    a_r6_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> wrap_i);

    // R7: the clear command leaves every value at its default
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (duty_act_q == '0 && en_act_q == '0 && duty_stg == '0
                     && en_stg == '0 && !run_q && state_q == CMD_IDLE));

    // R10: writes above the map change nothing
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i > AW'(CLR_A) && state_q == CMD_IDLE)
        |=> ($stable(duty_act_q) && $stable(duty_stg) && $stable(en_stg)
             && $stable(run_q) && state_q == CMD_IDLE));

endmodule

// File: rtl/ledpwm_chan.sv
`timescale 1ns/1ps
module ledpwm_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cnt_i,
    input  logic [DW-1:0] duty_i,
    input  logic          en_i,
    input  logic          run_i,
    output logic          pwm_o
);

    logic pwm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= run_i && en_i && (cnt_i < duty_i);
    end

    assign pwm_o = pwm_q;

    // R8/R9: stopped means low on the next cycle
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pwm_o);

    // R4: a disabled channel stays low
    a_r4_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o);

    // R2: zero duty never drives high
    a_r2_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_i == '0) |=> !pwm_o);

    // R2: full duty is high everywhere except the last phase
    a_r2_full: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && en_i && duty_i == '1 && cnt_i != '1) |=> pwm_o);

endmodule

// File: rtl/ledpwm_bank.sv
`timescale 1ns/1ps
module ledpwm_bank #(
    parameter int NCH = 18,
    parameter int DW  = 8,
    parameter int AW  = 8,
    parameter int ENB = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [AW-1:0]  wr_addr_i,
    input  logic [DW-1:0]  wr_data_i,
    input  logic           shdn_n_i,
    output logic [NCH-1:0] pwm_o
);

    logic [DW-1:0]          cnt;
    logic                   wrap;
    logic [NCH-1:0][DW-1:0] duty_act;
    logic [NCH-1:0]         en_act;
    logic                   run_bit;
    logic                   run;

    ledpwm_counter #(.DW(DW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    ledpwm_regs #(.NCH(NCH), .DW(DW), .AW(AW), .ENB(ENB)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .wrap_i     (wrap),
        .duty_act_o (duty_act),
        .en_act_o   (en_act),
        .run_o      (run_bit)
    );

    assign run = run_bit && shdn_n_i;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ledpwm_chan #(.DW(DW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_i  (cnt),
            .duty_i (duty_act[c]),
            .en_i   (en_act[c]),
            .run_i  (run),
            .pwm_o  (pwm_o[c])
        );
    end

    // R9: the shutdown pin silences every output on the next cycle
    a_r9_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_i |=> (pwm_o == '0));

endmodule

// File: tb/sim_ledpwm_bank.sv
`timescale 1ns/1ps
module sim_ledpwm_bank;

    localparam int NCH = 18;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic           shdn_n = 1'b1;
    logic [NCH-1:0] pwm;

    int n_chk = 0;
    int n_err = 0;
    int res [NCH];
    int exp_d [NCH];
    bit exp_e [NCH];

    always #2.5 clk = ~clk;

    ledpwm_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .shdn_n_i  (shdn_n),
        .pwm_o     (pwm)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (600) @(negedge clk);
    endtask

    task automatic measure();
        for (int c = 0; c < NCH; c++) res[c] = 0;
        repeat (256) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) res[c] += int'(pwm[c]);
        end
    endtask

    task automatic check_all(input string tag, input bit running);
        measure();
        for (int c = 0; c < NCH; c++)
            chk($sformatf("%s ch%0d", tag, c + 1), res[c],
                (running && exp_e[c]) ? exp_d[c] : 0);
    endtask

    task automatic t_reset();
        check_all("R1 reset outputs", 1'b0);
        wr(8'h01, 8'd128); wr(8'h13, 8'h01); wr(8'h16, 8'h00);
        settle();
        measure();
        chk("R1 stopped by default", res[0], 0);
        wr(8'h00, 8'h01);
        settle();
        exp_d[0] = 128; exp_e[0] = 1'b1;
        measure();
        chk("R2 ch1 duty 128", res[0], 128);
    endtask

    task automatic t_map();
        for (int c = 0; c < NCH; c++) begin
            exp_d[c] = (c == 0) ? 0 : (c == NCH - 1) ? 255 : c * 13 + 7;
            exp_e[c] = 1'b1;
            wr(8'(1 + c), 8'(exp_d[c]));
        end
        wr(8'h13, 8'hFF); wr(8'h14, 8'h3F); wr(8'h15, 8'h3F);
        wr(8'h16, 8'h00);
        settle();
        check_all("R2 R3 duty map", 1'b1);
    endtask

    task automatic t_enable();
        wr(8'h14, 8'h3E); wr(8'h15, 8'h1F);
        settle();
        check_all("R5 staged enables", 1'b1);
        wr(8'h16, 8'h00);
        settle();
        exp_e[6] = 1'b0; exp_e[17] = 1'b0;
        check_all("R4 enable bits", 1'b1);
        wr(8'h14, 8'h3F); wr(8'h15, 8'h3F); wr(8'h16, 8'h00);
        settle();
        exp_e[6] = 1'b1; exp_e[17] = 1'b1;
    endtask

    task automatic t_wrap();
        int run_len;
        int last_len;
        int last_rise;
        int runs;
        int t;
        bit prev;
        bit seen;
        wr(8'h01, 8'd40); wr(8'h16, 8'h00);
        settle();
        wr(8'h01, 8'd200);
        repeat (100) @(negedge clk);
        measure();
        chk("R5 staged duty not visible", res[0], 40);
        repeat (77) @(negedge clk);
        wr(8'h16, 8'h00);
        run_len = 0; last_len = 0; last_rise = -1; runs = 0; t = 0;
        prev = pwm[0]; seen = 1'b0;
        repeat (1200) begin
            @(negedge clk);
            t++;
            if (pwm[0] && !prev) begin
                if (last_rise >= 0) chk("R11 period", t - last_rise, 256);
                last_rise = t; seen = 1'b1; run_len = 0;
            end
            if (pwm[0]) run_len++;
            if (!pwm[0] && prev && seen) begin
                runs++;
                last_len = run_len;
                chk("R6 whole pulse", run_len, (run_len <= 120) ? 40 : 200);
            end
            prev = pwm[0];
        end
        chk("R6 new duty reached", last_len, 200);
        chk("R6 pulses observed", int'(runs >= 3), 1);
        exp_d[0] = 200;
    endtask

    task automatic t_ignore();
        wr(8'h01, 8'd50);
        wr(8'h16, 8'h01);
        settle();
        check_all("R10 nonzero update", 1'b1);
        wr(8'h17, 8'h05);
        wr(8'h18, 8'h00);
        wr(8'hFF, 8'h00);
        settle();
        check_all("R10 nonzero clear and unmapped", 1'b1);
        wr(8'h16, 8'h00);
        settle();
        exp_d[0] = 50;
        check_all("R10 staging survived", 1'b1);
    endtask

    task automatic t_soft();
        int hits;
        wr(8'h00, 8'h00);
        @(negedge clk);
        chk("R8 immediate stop", int'(pwm), 0);
        hits = 0;
        repeat (300) begin
            @(negedge clk);
            hits += int'(pwm != '0);
        end
        chk("R8 stays low", hits, 0);
        wr(8'h00, 8'h01);
        settle();
        check_all("R8 retained", 1'b1);
    endtask

    task automatic t_pin();
        int hits;
        @(negedge clk);
        shdn_n = 1'b0;
        @(negedge clk);
        chk("R9 pin off next cycle", int'(pwm), 0);
        hits = 0;
        repeat (300) begin
            @(negedge clk);
            hits += int'(pwm != '0);
        end
        chk("R9 stays low", hits, 0);
        shdn_n = 1'b1;
        settle();
        check_all("R9 retained", 1'b1);
    endtask

    task automatic t_clear();
        wr(8'h17, 8'h00);
        @(negedge clk);
        chk("R7 outputs low", int'(pwm), 0);
        wr(8'h00, 8'h01);
        settle();
        check_all("R7 active cleared", 1'b0);
        wr(8'h16, 8'h00);
        settle();
        check_all("R7 staging cleared", 1'b0);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            exp_d[c] = 0;
            exp_e[c] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_enable();
        t_wrap();
        t_ignore();
        t_soft();
        t_pin();
        t_clear();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1-all actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule